// File: doc/BRIEF.md
# Walking and Galloping RAM Pattern Tester

This block is a built-in test sequencer for a small single-port RAM. It drives the RAM's enable, write, address and write-data pins, and checks the read data that comes back one cycle after each read. The sequence first fills every word with a background value. Then it takes each word in turn as the test word: it stores the opposite value there, reads every other word to confirm that none was disturbed, reads the test word back, and restores the background. In galloping mode, every read of another word is followed at once by a read of the test word, so that every ordered pair of addresses is seen as a read-to-read transition. Run time grows with the square of the depth, so the block is meant for small memories such as register files, tag arrays and small buffers.

A pulse on `start` latches the mode and the complement option and begins the run. The run always finishes. Completion is shown by `done`, and the verdict by `pass` or `fail`. When the verdict is fail, the block also gives the test word and the address whose read data was wrong for the first mismatch it saw.

The controller is a single state machine with these states:
- IDLE: waits after reset.
- INIT: background fill.
- SET: writes the test value.
- SCAN: reads a neighbour.
- GAL: re-reads the test word after a neighbour read.
- CHK: reads the test word back.
- RESTORE: writes the background back.
- DONE: holds the result.

Its transitions are:
- IDLE or DONE to INIT on an accepted start.
- INIT loops on itself until the last address, then goes to SET.
- SET goes to SCAN.
- SCAN goes to GAL in galloping mode. In walking mode it stays in SCAN, or goes to CHK after the last neighbour.
- GAL goes back to SCAN, or to CHK after the last neighbour.
- CHK goes to RESTORE.
- RESTORE goes to SET for the next test word. After the last test word it goes to INIT for the complement pass, or to DONE.

Top module: `galpat_tester`

## Requirements
- R1: After reset, `mem_en`, `busy`, `done`, `pass` and `fail` are all 0.
- R2: An accepted start makes the next cycle the first of a background fill. The fill writes the background word to every address, from 0 up to DEPTH-1, one write per cycle with `mem_en`=1 and `mem_we`=1.
- R3: For each test address i, in ascending order, the block performs these operations in consecutive cycles:
  - It writes the test word to i.
  - It reads every address j other than i in ascending order, expecting the background. Address i is skipped without an idle cycle.
  - It reads i, expecting the test word.
  - It writes the background back to i.
- R4: With `gallop`=1 latched at start, each neighbour read in R3 is immediately followed by a read of address i that expects the test word. With `gallop`=0, no such re-read occurs.
- R5: The first pass uses an all-zeros background and an all-ones test word. With `two_pass`=1 latched at start, a second pass follows at once. The second pass uses an all-ones background and an all-zeros test word, and starts with its own fill.
- R6: `mem_en` stays 1 in every cycle from the first fill write to the final restore. A walking pass takes DEPTH²+3·DEPTH cycles and a galloping pass takes 2·DEPTH²+2·DEPTH cycles. `done` rises in the cycle right after the last operation, with `mem_en`=0.
- R7: While `done`=1, `pass`=1 if every read returned its expected word, and `fail`=1 otherwise. The two are never both 1. On fail, `fail_cell` holds the test address and `fail_addr` holds the read address of the first mismatching read.
- R8: A `start` pulse while `busy`=1 has no effect on the operation stream.
- R9: Changes on `gallop` and `two_pass` after the start cycle have no effect on the run in progress.
- R10: `done` and the verdict hold until the next start. A start while `done`=1 begins a new run and clears the previous verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run when idle or done |
| gallop | input | 1 | 1 selects galloping, 0 selects walking; latched at start |
| two_pass | input | 1 | 1 adds the complement pass; latched at start |
| mem_rdata | input | DATA_W | RAM read data, valid one cycle after a read |
| mem_en | output | 1 | RAM access enable |
| mem_we | output | 1 | RAM write enable (read when 0) |
| mem_addr | output | AW | RAM address, AW = clog2(DEPTH) |
| mem_wdata | output | DATA_W | RAM write data |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished, verdict valid |
| pass | output | 1 | Done with no mismatch |
| fail | output | 1 | Done with at least one mismatch |
| fail_cell | output | AW | Test address of the first mismatch |
| fail_addr | output | AW | Read address of the first mismatch |

## Verification
A wrong counter or state in the sequencer shows up on the RAM pins in the very cycle it occurs. Examples are a skipped or repeated neighbour, a missing re-read, or a wrong background after the pass change. Each shows as an address, direction or data word that differs from the expected stream, so the bench compares the pins every cycle against an operation queue it builds from the requirements. A fault in the compare path only shows when `done` rises, as a wrong verdict or a wrong address pair. To expose it, the bench's RAM model can inject a coupling fault, a stuck bit, or a fault that appears only on one read-to-read address transition. The last of these separates galloping from walking.

// File: rtl/galpat_pkg.sv
package galpat_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_INIT,
        ST_SET,
        ST_SCAN,
        ST_GAL,
        ST_CHK,
        ST_RESTORE,
        ST_DONE
    } gp_state_e;

endpackage

// File: rtl/galpat_seq.sv
module galpat_seq
    import galpat_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 8,
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              gallop,
    input  logic              two_pass,
    output logic              mem_en,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              rd_issue,
    output logic [DATA_W-1:0] rd_exp,
    output logic [AW-1:0]     rd_cell,
    output logic              run_start,
    output logic              busy,
    output logic              done
);

    localparam logic [AW-1:0] LAST_A = AW'(DEPTH - 1);
    localparam logic [AW-1:0] PREV_A = AW'(DEPTH - 2);

    gp_state_e   state_q, state_d;
    logic [AW-1:0] i_q, j_q;
    logic          gal_q, two_q, cmp_q;

    logic [DATA_W-1:0] bg_w, tv_w;
    logic [AW-1:0]     first_j, next_j;
    logic              j_last, i_last, accept;

    assign bg_w    = {DATA_W{cmp_q}};
    assign tv_w    = ~bg_w;
    assign first_j = (i_q == '0) ? AW'(1) : '0;
    assign next_j  = ((j_q + AW'(1)) == i_q) ? (j_q + AW'(2)) : (j_q + AW'(1));
    assign i_last  = (i_q == LAST_A);
    assign j_last  = (j_q == LAST_A) || (i_last && (j_q == PREV_A));
    assign accept  = start && ((state_q == ST_IDLE) || (state_q == ST_DONE));
    assign run_start = accept;

    // next-state decode
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (accept) state_d = ST_INIT;
            ST_DONE:    if (accept) state_d = ST_INIT;
            ST_INIT:    if (j_q == LAST_A) state_d = ST_SET;
            ST_SET:     state_d = ST_SCAN;
            ST_SCAN: begin
                if (gal_q)       state_d = ST_GAL;
                else if (j_last) state_d = ST_CHK;
            end
            ST_GAL:     state_d = j_last ? ST_CHK : ST_SCAN;
            ST_CHK:     state_d = ST_RESTORE;
            ST_RESTORE: begin
                if (!i_last)             state_d = ST_SET;
                else if (two_q && !cmp_q) state_d = ST_INIT;
                else                     state_d = ST_DONE;
            end
            default:    state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // loop counters and run configuration
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            i_q   <= '0;
            j_q   <= '0;
            gal_q <= 1'b0;
            two_q <= 1'b0;
            cmp_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE, ST_DONE: begin
                    if (accept) begin
                        j_q   <= '0;
                        i_q   <= '0;
                        gal_q <= gallop;
                        two_q <= two_pass;
                        cmp_q <= 1'b0;
                    end
                end
                ST_INIT: begin
                    if (j_q == LAST_A) i_q <= '0;
                    else               j_q <= j_q + AW'(1);
                end
                ST_SET:  j_q <= first_j;
                ST_SCAN: begin
                    if (!gal_q && !j_last) j_q <= next_j;
                end
                ST_GAL: begin
                    if (!j_last) j_q <= next_j;
                end
                ST_CHK: ;
                ST_RESTORE: begin
                    if (!i_last) begin
                        i_q <= i_q + AW'(1);
                    end else if (two_q && !cmp_q) begin
                        cmp_q <= 1'b1;
                        j_q   <= '0;
                    end
                end
                default: ;
            endcase
        end
    end

    // RAM pins and read expectations
    always_comb begin
        mem_en    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = bg_w;
        rd_exp    = bg_w;
        unique case (state_q)
            ST_INIT: begin
                mem_en = 1'b1; mem_we = 1'b1; mem_addr = j_q; mem_wdata = bg_w;
            end
            ST_SET: begin
                mem_en = 1'b1; mem_we = 1'b1; mem_addr = i_q; mem_wdata = tv_w;
            end
            ST_SCAN: begin
                mem_en = 1'b1; mem_addr = j_q; rd_exp = bg_w;
            end
            ST_GAL, ST_CHK: begin
                mem_en = 1'b1; mem_addr = i_q; rd_exp = tv_w;
            end
            ST_RESTORE: begin
                mem_en = 1'b1; mem_we = 1'b1; mem_addr = i_q; mem_wdata = bg_w;
            end
            default: ;
        endcase
    end

    assign rd_issue = mem_en && !mem_we;
    assign rd_cell  = i_q;
    assign busy     = (state_q != ST_IDLE) && (state_q != ST_DONE);
    assign done     = (state_q == ST_DONE);

    p_scan_skip_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SCAN) |-> (mem_addr != i_q));

    p_gal_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SCAN && gal_q) |=> (mem_en && !mem_we && mem_addr == $past(i_q)));

    p_walk_noreread_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SCAN && !gal_q) |=> (state_q != ST_GAL));

    p_second_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmp_q) |-> (two_q && state_q == ST_INIT));

    p_cfg_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(gal_q) && $stable(two_q)));

endmodule

// File: rtl/galpat_cmp.sv
module galpat_cmp #(
    parameter int DATA_W = 8,
    parameter int AW     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              rd_issue,
    input  logic [DATA_W-1:0] rd_exp,
    input  logic [AW-1:0]     rd_cell,
    input  logic [AW-1:0]     rd_addr,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              err,
    output logic [AW-1:0]     fail_cell,
    output logic [AW-1:0]     fail_addr
);

    logic              pend_q;
    logic [DATA_W-1:0] pexp_q;
    logic [AW-1:0]     pcell_q, paddr_q;
    logic              miss;

    assign miss = pend_q && (mem_rdata != pexp_q);

    // one-deep pipeline matching the RAM read latency
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q  <= 1'b0;
            pexp_q  <= '0;
            pcell_q <= '0;
            paddr_q <= '0;
        end else begin
            pend_q  <= rd_issue;
            pexp_q  <= rd_exp;
            pcell_q <= rd_cell;
            paddr_q <= rd_addr;
        end
    end

    // first-mismatch capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err       <= 1'b0;
            fail_cell <= '0;
            fail_addr <= '0;
        end else if (clr) begin
            err       <= 1'b0;
            fail_cell <= '0;
            fail_addr <= '0;
        end else if (miss && !err) begin
            err       <= 1'b1;
            fail_cell <= pcell_q;
            fail_addr <= paddr_q;
        end
    end

    p_first_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !clr) |=> (err && $stable(fail_cell) && $stable(fail_addr)));

endmodule

// File: rtl/galpat_tester.sv
module galpat_tester #(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 8,
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              gallop,
    input  logic              two_pass,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_en,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              busy,
    output logic              done,
    output logic              pass,
    output logic              fail,
    output logic [AW-1:0]     fail_cell,
    output logic [AW-1:0]     fail_addr
);

    logic              rd_issue, run_start, err;
    logic [DATA_W-1:0] rd_exp;
    logic [AW-1:0]     rd_cell;

    galpat_seq #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .gallop    (gallop),
        .two_pass  (two_pass),
        .mem_en    (mem_en),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .rd_issue  (rd_issue),
        .rd_exp    (rd_exp),
        .rd_cell   (rd_cell),
        .run_start (run_start),
        .busy      (busy),
        .done      (done)
    );

    galpat_cmp #(.DATA_W(DATA_W), .AW(AW)) u_cmp (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (run_start),
        .rd_issue  (rd_issue),
        .rd_exp    (rd_exp),
        .rd_cell   (rd_cell),
        .rd_addr   (mem_addr),
        .mem_rdata (mem_rdata),
        .err       (err),
        .fail_cell (fail_cell),
        .fail_addr (fail_addr)
    );

    assign pass = done && !err;
    assign fail = done && err;

    p_done_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_en);

    p_busy_stream_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> mem_en);

endmodule

// File: tb/galpat_tester_tb.sv
`timescale 1ns/1ps
module galpat_tester_tb;

    localparam int DEPTH = 8;
    localparam int W     = 8;
    localparam int AW    = $clog2(DEPTH);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, gallop = 1'b0, two_pass = 1'b0;
    logic [W-1:0]  mem_rdata;
    logic          mem_en, mem_we, busy, done, pass, fail;
    logic [AW-1:0] mem_addr, fail_cell, fail_addr;
    logic [W-1:0]  mem_wdata;

    always #2 clk = ~clk;

    galpat_tester #(.DEPTH(DEPTH), .DATA_W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .gallop(gallop), .two_pass(two_pass),
        .mem_rdata(mem_rdata), .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .busy(busy), .done(done), .pass(pass), .fail(fail),
        .fail_cell(fail_cell), .fail_addr(fail_addr)
    );

    int checks = 0, errors = 0;
    bit finished = 0;

    // bench RAM with injectable faults: 0 none, 1 stuck bit, 2 coupling, 3 transition
    int fk = 0;
    localparam logic [AW-1:0] STK_A = 3'd6, CPL_A = 3'd2, CPL_V = 3'd5;
    localparam logic [AW-1:0] TRN_FROM = 3'd3, TRN_TO = 3'd1;
    logic [W-1:0]  bram [DEPTH];
    logic [AW-1:0] prev_a = '0;
    logic          prev_v = 1'b0;

    function automatic logic [W-1:0] bram_val(input logic [AW-1:0] a);
        logic [W-1:0] v;
        v = bram[a];
        if (fk == 1 && a == STK_A) v[0] = 1'b1;
        if (fk == 3 && a == TRN_TO && prev_v && prev_a == TRN_FROM) v[0] = ~v[0];
        return v;
    endfunction

    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) begin
                bram[mem_addr] <= mem_wdata;
                if (fk == 2 && mem_addr == CPL_A) bram[CPL_V] <= mem_wdata;
            end else begin
                mem_rdata <= bram_val(mem_addr);
                prev_a    <= mem_addr;
                prev_v    <= 1'b1;
            end
        end
    end

    // expected operation stream
    logic          q_we   [$];
    logic [AW-1:0] q_addr [$];
    logic [W-1:0]  q_dat  [$];
    logic [AW-1:0] q_cell [$];

    task automatic push_op(input logic we, input int a, input logic [W-1:0] d, input int c);
        q_we.push_back(we);
        q_addr.push_back(AW'(a));
        q_dat.push_back(d);
        q_cell.push_back(AW'(c));
    endtask

    task automatic build(input bit gal, input bit two);
        for (int p = 0; p <= (two ? 1 : 0); p++) begin
            logic [W-1:0] bg;
            bg = (p == 1) ? '1 : '0;
            for (int a = 0; a < DEPTH; a++) push_op(1'b1, a, bg, 0);
            for (int i = 0; i < DEPTH; i++) begin
                push_op(1'b1, i, ~bg, i);
                for (int j = 0; j < DEPTH; j++) begin
                    if (j != i) begin
                        push_op(1'b0, j, bg, i);
                        if (gal) push_op(1'b0, i, ~bg, i);
                    end
                end
                push_op(1'b0, i, ~bg, i);
                push_op(1'b1, i, bg, i);
            end
        end
    endtask

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic run(input bit gal, input bit two, input int fault, input bit poke);
        int n, nexp, per;
        bit mf;
        logic [AW-1:0] mcell, maddr;
        fk = fault;
        mf = 0; mcell = '0; maddr = '0;
        build(gal, two);
        per  = gal ? (2*DEPTH*DEPTH + 2*DEPTH) : (DEPTH*DEPTH + 3*DEPTH);
        nexp = two ? 2*per : per;
        start = 1'b1; gallop = gal; two_pass = two;
        @(negedge clk);
        start = 1'b0;
        n = 0;
        while (q_addr.size() > 0) begin
            // R2 R3 R4 R5: pins match the expected stream
            chk(mem_en && mem_we == q_we[0] && mem_addr == q_addr[0] &&
                (!q_we[0] || mem_wdata == q_dat[0]),
                "R3", $sformatf("op %0d addr/we/data", n),
                {mem_en, mem_we, mem_addr, mem_wdata},
                {1'b1, q_we[0], q_addr[0], q_we[0] ? q_dat[0] : mem_wdata});
            if (!q_we[0] && !mf && bram_val(q_addr[0]) != q_dat[0]) begin
                mf = 1; mcell = q_cell[0]; maddr = q_addr[0];
            end
            void'(q_we.pop_front()); void'(q_addr.pop_front());
            void'(q_dat.pop_front()); void'(q_cell.pop_front());
            if (poke && n == 20) begin
                start = 1'b1; gallop = ~gal; two_pass = ~two;   // R8 R9
            end else begin
                start = 1'b0;
            end
            n++;
            @(negedge clk);
        end
        start = 1'b0;
        chk(n == nexp, "R6", "operation count", n, nexp);
        chk(done && !mem_en, "R6", "done right after last op", {done, mem_en}, 2'b10);
        chk(pass == !mf && fail == mf, "R7", "verdict", {pass, fail}, {!mf, mf});
        if (mf) begin
            chk(fail_cell == mcell, "R7", "fail_cell", fail_cell, mcell);
            chk(fail_addr == maddr, "R7", "fail_addr", fail_addr, maddr);
        end
        gallop = 1'b0; two_pass = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!mem_en && !busy && !done && !pass && !fail, "R1", "reset outputs",
            {mem_en, busy, done, pass, fail}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!mem_en && !done, "R1", "idle after reset", {mem_en, done}, 0);

        run(0, 0, 0, 0);          // R3 walking clean
        run(1, 0, 0, 0);          // R4 galloping clean
        run(0, 1, 0, 0);          // R5 complement pass
        run(1, 1, 0, 1);          // R8 R9 poke mid-run
        run(0, 0, 2, 0);          // R7 coupling fault
        run(1, 1, 1, 0);          // R7 stuck bit
        run(0, 0, 3, 0);          // R4 transition fault invisible to walking
        chk(pass, "R4", "walking misses transition fault", pass, 1);
        run(1, 0, 3, 0);          // R4 galloping finds it
        chk(fail, "R4", "galloping finds transition fault", fail, 1);

        // R10 hold, then restart from done clears verdict
        repeat (3) @(negedge clk);
        chk(done && fail && !mem_en, "R10", "verdict held", {done, fail, mem_en}, 3'b110);
        run(0, 0, 0, 0);
        chk(pass && !fail, "R10", "restart clears verdict", {pass, fail}, 2'b10);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule